// File: doc/BRIEF.md
# SPI Master Register Front End

This block is the software-visible face of an SPI master. Software talks to it over a simple synchronous bus with one-cycle reads and writes. It holds two control registers, a bit-rate register, a status register and a data port. A byte written to the data port waits in a one-byte holding buffer. The buffer hands the byte to a separate shift engine through a start/done handshake. The engine returns the received byte, which lands in a receive register.

Two flags report progress: "transmit buffer empty" and "transfer complete". Each flag clears only after a two-step access. The first step is a status read that sees the flag set. The second step is a data-port read (for the receive flag) or a data-port write (for the transmit flag). A write to the data port that has not been armed by such a status read is dropped. An interrupt request combines the two flags with their enables. A mode-fault flag records a fault reported from outside the block.

The shift engine reads the configuration outputs: enable, master, clock polarity, clock phase, bit order and the bit-clock divisor. The block computes the divisor as (prescale+1)·2^(rate+1).

Top module: `spi_reg_front`

## Requirements
- R1: Register map: address 0 = control A, 1 = control B, 2 = bit-rate, 3 = status, 4 = data. Addresses 5..7 read 0. After reset, reads return 0x04, 0x08, 0x00, 0x20 and 0x00 for addresses 0 to 4.
- R2: Control B keeps only bits 4,3,1,0 (mask 0x1B). Bit-rate keeps only bits 6:4 and 2:0 (mask 0x77). Status bits 6 and 3:0 always read 0. Writes to the status address have no effect.
- R3: Control A fields drive the configuration outputs as follows: bit 6 = enable, bit 4 = master, bit 3 = polarity, bit 2 = phase, bit 0 = LSB first. Bit 7 enables the receive interrupt and bit 5 enables the transmit interrupt. The output cfg_divisor equals (bit-rate[6:4]+1)·2^(bit-rate[2:0]+1).
- R4: A data-port write is accepted only in a specific case. The block must be enabled, and the status read since the last accepted write must have seen status bit 5 (transmit empty) set. In that case the byte is taken and bit 5 drops to 0. Otherwise the write is ignored.
- R5: A held byte is launched when the block is enabled, in master mode, and the engine is idle. The clock edge after acceptance raises xfer_start for exactly one cycle, with xfer_byte carrying the byte, and status bit 5 returns to 1 at the same edge. A byte queued while the engine is busy waits for xfer_done.
- R6: xfer_done arriving while a transfer is running copies xfer_rx into the data register and sets status bit 7 (complete). Data-port reads return the received byte. xfer_done is ignored when no transfer is running.
- R7: Status bit 7 clears only when a data-port read follows a status read that saw bit 7 set. A data read without that prior status read leaves bit 7 at 1.
- R8: irq = enable AND ((ctrlA[7] AND status[7]) OR (ctrlA[5] AND status[5])).
- R9: Clearing the enable bit aborts the running transfer and drops any held byte. Status bit 5 then reads 1, and a later xfer_done does not set bit 7.
- R10: fault_in sets status bit 4 when control B bit 4 is 1 and the block is enabled in master mode. Bit 4 clears when a write to control A follows a status read that saw bit 4 set.
- R11: Writing 0x10 to bit-rate and 0x50 to control A selects the following: enabled, master, polarity 0, phase 0, MSB first, irq low, and divisor 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0 when not reading) |
| irq | output | 1 | Interrupt request |
| cfg_enable | output | 1 | Block enable |
| cfg_master | output | 1 | Master mode |
| cfg_cpol | output | 1 | Clock idle level |
| cfg_cpha | output | 1 | Clock phase |
| cfg_lsb_first | output | 1 | Bit order |
| cfg_divisor | output | DIV_W | Bit-clock divisor |
| xfer_start | output | 1 | One-cycle launch strobe to engine |
| xfer_byte | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Engine finished a byte |
| xfer_rx | input | 8 | Byte shifted in |
| fault_in | input | 1 | Mode-fault report |

## Verification
The assertions check the following on every cycle:
- xfer_start is a single-cycle pulse that appears only while the block is enabled.
- The complete flag rises only on a live done.
- The complete flag falls only on an armed data read.
- The empty flag falls only on an accepted write.
- Disabling the block forces the empty flag high and silences irq.
- Reserved status bits read 0.

Some behaviour only the bench scenarios can show, comparing against a behavioural model:
- Unarmed writes and reads are dropped.
- A byte queued behind a busy engine waits.
- Done pulses after an abort are ignored.
- The fault flag's set and clear sequence.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;
  localparam int REG_W  = 8;
  localparam int PRE_W  = 3;
  localparam int RATE_W = 3;
  localparam int DIV_W  = PRE_W + (1 << RATE_W) + 1;

  localparam logic [2:0] A_CTRLA = 3'd0;
  localparam logic [2:0] A_CTRLB = 3'd1;
  localparam logic [2:0] A_RATE  = 3'd2;
  localparam logic [2:0] A_STAT  = 3'd3;
  localparam logic [2:0] A_DATA  = 3'd4;

  localparam logic [REG_W-1:0] CTRLA_RST = 8'h04;
  localparam logic [REG_W-1:0] CTRLB_RST = 8'h08;
  localparam logic [REG_W-1:0] CTRLB_MSK = 8'h1B;
  localparam logic [REG_W-1:0] RATE_MSK  = 8'h77;

  // control A field positions
  localparam int CA_RXIE = 7;
  localparam int CA_EN   = 6;
  localparam int CA_TXIE = 5;
  localparam int CA_MST  = 4;
  localparam int CA_POL  = 3;
  localparam int CA_PHA  = 2;
  localparam int CA_LSB  = 0;
  localparam int CB_FLTEN = 4;

  function automatic logic [DIV_W-1:0] bit_divisor(input logic [PRE_W-1:0] pre,
                                                   input logic [RATE_W-1:0] rate);
    logic [DIV_W-1:0] base;
    base = DIV_W'(pre) + DIV_W'(1);
    return base << (DIV_W'(rate) + DIV_W'(1));
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic cmp, input logic emp,
                                                   input logic flt);
    return {cmp, 1'b0, emp, flt, 4'b0000};
  endfunction
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_front_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_a,
  input  logic             wr_b,
  input  logic             wr_rate,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_a,
  output logic [REG_W-1:0] ctrl_b,
  output logic [REG_W-1:0] rate
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_a <= CTRLA_RST;
      ctrl_b <= CTRLB_RST;
      rate   <= '0;
    end else begin
      if (wr_a)    ctrl_a <= wdata;
      if (wr_b)    ctrl_b <= wdata & CTRLB_MSK;
      if (wr_rate) rate   <= wdata & RATE_MSK;
    end
  end
endmodule

// File: rtl/spi_tx_queue.sv
module spi_tx_queue
  import spi_front_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             master,
  input  logic             stat_rd,
  input  logic             data_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             done_in,
  output logic             empty,
  output logic             start,
  output logic [REG_W-1:0] start_byte,
  output logic             accept_evt,
  output logic             launch_evt,
  output logic             done_evt
);
  logic             full_q, busy_q, arm_q;
  logic [REG_W-1:0] hold_q;

  assign accept_evt = en && data_wr && arm_q && !full_q;
  assign launch_evt = en && master && full_q && !busy_q;
  assign done_evt   = en && busy_q && done_in;
  assign empty      = !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      busy_q     <= 1'b0;
      arm_q      <= 1'b0;
      start      <= 1'b0;
      hold_q     <= '0;
      start_byte <= '0;
    end else if (!en) begin
      full_q <= 1'b0;
      busy_q <= 1'b0;
      arm_q  <= 1'b0;
      start  <= 1'b0;
    end else begin
      start <= launch_evt;
      if (stat_rd)         arm_q <= !full_q;
      else if (accept_evt) arm_q <= 1'b0;
      if (accept_evt) begin
        hold_q <= wdata;
        full_q <= 1'b1;
      end else if (launch_evt) begin
        full_q <= 1'b0;
      end
      if (launch_evt) begin
        busy_q     <= 1'b1;
        start_byte <= hold_q;
      end else if (done_evt) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags
  import spi_front_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  logic [REG_W-1:0] rx_in,
  input  logic             stat_rd,
  input  logic             data_rd,
  input  logic             ctrl_a_wr,
  input  logic             fault_evt,
  output logic             complete,
  output logic             fault,
  output logic [REG_W-1:0] rx_data,
  output logic             rx_clear_evt,
  output logic             fault_clear_evt
);
  logic arm_rx_q, arm_flt_q;

  assign rx_clear_evt    = data_rd && arm_rx_q;
  assign fault_clear_evt = ctrl_a_wr && arm_flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_rx_q  <= 1'b0;
      arm_flt_q <= 1'b0;
      complete  <= 1'b0;
      fault     <= 1'b0;
      rx_data   <= '0;
    end else begin
      if (stat_rd) begin
        arm_rx_q  <= complete;
        arm_flt_q <= fault;
      end else begin
        if (rx_clear_evt)    arm_rx_q  <= 1'b0;
        if (fault_clear_evt) arm_flt_q <= 1'b0;
      end
      if (done_evt) begin
        complete <= 1'b1;
        rx_data  <= rx_in;
      end else if (rx_clear_evt) begin
        complete <= 1'b0;
      end
      if (fault_evt)            fault <= 1'b1;
      else if (fault_clear_evt) fault <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_front_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              cfg_enable,
  output logic              cfg_master,
  output logic              cfg_cpol,
  output logic              cfg_cpha,
  output logic              cfg_lsb_first,
  output logic [DIV_W-1:0]  cfg_divisor,
  output logic              xfer_start,
  output logic [7:0]        xfer_byte,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  input  logic              fault_in
);
  logic [REG_W-1:0] ctrl_a, ctrl_b, rate, rx_data;
  logic rd_en, wr_en, hit_a, hit_b, hit_rate, hit_stat, hit_data;
  logic stat_rd, data_rd, data_wr;
  logic empty, complete, fault, fault_evt;
  logic accept_evt, launch_evt, done_evt, rx_clear_evt, fault_clear_evt;

  assign rd_en    = bus_sel && !bus_wr;
  assign wr_en    = bus_sel && bus_wr;
  assign hit_a    = bus_addr == ADDR_W'(A_CTRLA);
  assign hit_b    = bus_addr == ADDR_W'(A_CTRLB);
  assign hit_rate = bus_addr == ADDR_W'(A_RATE);
  assign hit_stat = bus_addr == ADDR_W'(A_STAT);
  assign hit_data = bus_addr == ADDR_W'(A_DATA);
  assign stat_rd  = rd_en && hit_stat;
  assign data_rd  = rd_en && hit_data;
  assign data_wr  = wr_en && hit_data;

  spi_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_a(wr_en && hit_a), .wr_b(wr_en && hit_b), .wr_rate(wr_en && hit_rate),
    .wdata(bus_wdata), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .rate(rate)
  );

  assign cfg_enable    = ctrl_a[CA_EN];
  assign cfg_master    = ctrl_a[CA_MST];
  assign cfg_cpol      = ctrl_a[CA_POL];
  assign cfg_cpha      = ctrl_a[CA_PHA];
  assign cfg_lsb_first = ctrl_a[CA_LSB];
  assign cfg_divisor   = bit_divisor(rate[6:4], rate[2:0]);

  spi_tx_queue u_tx (
    .clk(clk), .rst_n(rst_n), .en(cfg_enable), .master(cfg_master),
    .stat_rd(stat_rd), .data_wr(data_wr), .wdata(bus_wdata), .done_in(xfer_done),
    .empty(empty), .start(xfer_start), .start_byte(xfer_byte),
    .accept_evt(accept_evt), .launch_evt(launch_evt), .done_evt(done_evt)
  );

  assign fault_evt = fault_in && ctrl_b[CB_FLTEN] && cfg_enable && cfg_master;

  spi_rx_flags u_rx (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .rx_in(xfer_rx),
    .stat_rd(stat_rd), .data_rd(data_rd), .ctrl_a_wr(wr_en && hit_a),
    .fault_evt(fault_evt), .complete(complete), .fault(fault), .rx_data(rx_data),
    .rx_clear_evt(rx_clear_evt), .fault_clear_evt(fault_clear_evt)
  );

  assign irq = cfg_enable && ((ctrl_a[CA_RXIE] && complete) || (ctrl_a[CA_TXIE] && empty));

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (hit_a)         bus_rdata = ctrl_a;
      else if (hit_b)    bus_rdata = ctrl_b;
      else if (hit_rate) bus_rdata = rate;
      else if (hit_stat) bus_rdata = pack_status(complete, empty, fault);
      else if (hit_data) bus_rdata = rx_data;
    end
  end
endmodule

// File: rtl/spi_front_chk.sv
module spi_front_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              irq,
  input logic              cfg_enable,
  input logic              xfer_start,
  input logic              empty,
  input logic              complete,
  input logic              done_evt,
  input logic              accept_evt,
  input logic              rx_clear_evt
);
  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  assert_start_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_start) |-> $past(cfg_enable));
  assert_cmp_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(complete) |-> $past(done_evt));
  assert_cmp_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(complete) |-> $past(rx_clear_evt));
  assert_empty_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> $past(accept_evt));
  assert_abort_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> empty);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !irq);
  assert_stat_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(3)) |-> ((bus_rdata & 8'h4F) == 8'h00));
endmodule

bind spi_reg_front spi_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq(irq), .cfg_enable(cfg_enable), .xfer_start(xfer_start),
  .empty(empty), .complete(complete), .done_evt(done_evt), .accept_evt(accept_evt),
  .rx_clear_evt(rx_clear_evt)
);

// File: tb/test_spi_reg_front.sv
`timescale 1ns/1ps
module test_spi_reg_front;
  localparam int ENG_LAT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, cfg_enable, cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic [11:0] cfg_divisor;
  logic xfer_start;
  logic [7:0] xfer_byte;
  logic xfer_done = 1'b0;
  logic [7:0] xfer_rx = '0;
  logic fault_in = 1'b0;

  always #2 clk = ~clk;

  spi_reg_front i_spi_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cfg_enable(cfg_enable),
    .cfg_master(cfg_master), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_divisor(cfg_divisor), .xfer_start(xfer_start),
    .xfer_byte(xfer_byte), .xfer_done(xfer_done), .xfer_rx(xfer_rx), .fault_in(fault_in)
  );

  int total = 0, bad = 0;
  bit fin = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_a, m_b, m_rate, m_rx, m_hold, m_byte;
  bit m_cmp, m_flt, m_full, m_busy, m_arm_rx, m_arm_tx, m_arm_flt, m_start;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = 8'h04; m_b = 8'h08; m_rate = 8'h00; m_rx = 0; m_hold = 0; m_byte = 0;
      m_cmp = 0; m_flt = 0; m_full = 0; m_busy = 0;
      m_arm_rx = 0; m_arm_tx = 0; m_arm_flt = 0; m_start = 0;
    end else begin
      bit rd, wr, on, mst, go, take, dn;
      logic [7:0] na, nb, nr;
      rd = bus_sel && !bus_wr; wr = bus_sel && bus_wr;
      on = m_a[6]; mst = m_a[4];
      na = m_a; nb = m_b; nr = m_rate;
      if (wr && bus_addr == 0) na = bus_wdata;
      if (wr && bus_addr == 1) nb = bus_wdata & 8'h1B;
      if (wr && bus_addr == 2) nr = bus_wdata & 8'h77;
      // fault flag
      if (fault_in && m_b[4] && on && mst) m_flt = 1;
      else if (wr && bus_addr == 0 && m_arm_flt) m_flt = 0;
      // receive side
      dn = on && m_busy && xfer_done;
      if (dn) begin m_cmp = 1; m_rx = xfer_rx; end
      else if (rd && bus_addr == 4 && m_arm_rx) m_cmp = 0;
      if (rd && bus_addr == 3) begin
        m_arm_rx = m_cmp_prev(); m_arm_flt = m_flt_prev();
      end else begin
        if (rd && bus_addr == 4) m_arm_rx = 0;
        if (wr && bus_addr == 0) m_arm_flt = 0;
      end
      // transmit side
      if (!on) begin
        m_full = 0; m_busy = 0; m_arm_tx = 0; m_start = 0;
      end else begin
        go = m_full && !m_busy && mst;
        take = wr && bus_addr == 4 && m_arm_tx && !m_full;
        m_start = go;
        if (rd && bus_addr == 3) m_arm_tx = !m_full;
        else if (take) m_arm_tx = 0;
        if (dn) m_busy = 0;
        if (go) begin m_byte = m_hold; m_busy = 1; m_full = 0; end
        if (take) begin m_hold = bus_wdata; m_full = 1; end
      end
      m_a = na; m_b = nb; m_rate = nr;
      snap_cmp = m_cmp; snap_flt = m_flt;
    end
  end

  // values of the flags as seen before this edge (for arming)
  bit snap_cmp = 0, snap_flt = 0;
  function automatic bit m_cmp_prev(); return snap_cmp; endfunction
  function automatic bit m_flt_prev(); return snap_flt; endfunction

  function automatic logic [7:0] exp_rd();
    if (!(bus_sel && !bus_wr)) return 8'h00;
    case (bus_addr)
      3'd0: return m_a;
      3'd1: return m_b;
      3'd2: return m_rate;
      3'd3: return {m_cmp, 1'b0, !m_full, m_flt, 4'b0};
      3'd4: return m_rx;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int exp_div(input logic [7:0] r);
    int d;
    d = int'(r[6:4]) + 1;
    for (int k = 0; k <= int'(r[2:0]); k++) d = d * 2;
    return d;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      bit eirq;
      eirq = m_a[6] && ((m_a[7] && m_cmp) || (m_a[5] && !m_full));
      chk(bus_rdata === exp_rd(), "R1 read data vs model", bus_rdata, exp_rd());
      chk(irq === eirq, "R8 irq vs model", irq, eirq);
      chk(xfer_start === m_start, "R5 start vs model", xfer_start, m_start);
      if (m_start) chk(xfer_byte === m_byte, "R5 launch byte vs model", xfer_byte, m_byte);
      chk(cfg_divisor == exp_div(m_rate), "R3 divisor vs model", cfg_divisor, exp_div(m_rate));
      chk({cfg_enable, cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first} ===
          {m_a[6], m_a[4], m_a[3], m_a[2], m_a[0]}, "R3 config bits vs model",
          {cfg_enable, cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first},
          {m_a[6], m_a[4], m_a[3], m_a[2], m_a[0]});
    end
  end

  // ---------------- shift-engine stand-in ----------------
  bit eng_auto = 1'b1, req_done = 1'b0;
  int eng_cnt = 0, n_start = 0;
  logic [7:0] last_byte = 0;
  always @(posedge clk) begin
    #1;
    xfer_done = 1'b0;
    if (eng_cnt > 0) begin
      eng_cnt--;
      if (eng_cnt == 0) xfer_done = 1'b1;
    end
    if (req_done) begin xfer_done = 1'b1; req_done = 1'b0; end
    if (xfer_start) begin
      chk(eng_cnt == 0, "R5 launch while engine busy", eng_cnt, 0);
      n_start++;
      last_byte = xfer_byte;
      if (eng_auto) begin eng_cnt = ENG_LAT; xfer_rx = xfer_byte ^ 8'hA5; end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values and map
    rd_reg(0, v); chk(v == 8'h04, "R1 ctrlA reset", v, 8'h04);
    rd_reg(1, v); chk(v == 8'h08, "R1 ctrlB reset", v, 8'h08);
    rd_reg(2, v); chk(v == 8'h00, "R1 rate reset", v, 8'h00);
    rd_reg(3, v); chk(v == 8'h20, "R1 status reset", v, 8'h20);
    rd_reg(4, v); chk(v == 8'h00, "R1 data reset", v, 8'h00);
    rd_reg(7, v); chk(v == 8'h00, "R1 unused address", v, 8'h00);

    // R2 reserved bits
    wr_reg(1, 8'hFF); rd_reg(1, v); chk(v == 8'h1B, "R2 ctrlB mask", v, 8'h1B);
    wr_reg(2, 8'hFF); rd_reg(2, v); chk(v == 8'h77, "R2 rate mask", v, 8'h77);
    wr_reg(3, 8'hFF); rd_reg(3, v); chk(v == 8'h20, "R2 status write ignored", v, 8'h20);
    wr_reg(1, 8'h08);

    // R11 example setup
    wr_reg(2, 8'h10); wr_reg(0, 8'h50); idle(1);
    chk(cfg_divisor == 4, "R11 divisor", cfg_divisor, 4);
    chk({cfg_enable, cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first, irq} == 6'b110000,
        "R11 mode bits", {cfg_enable, cfg_master, cfg_cpol, cfg_cpha, cfg_lsb_first, irq},
        6'b110000);

    // R3 other field values
    wr_reg(2, 8'h73); idle(1);
    chk(cfg_divisor == 128, "R3 divisor 8*16", cfg_divisor, 128);
    wr_reg(0, 8'h5D); idle(1);
    chk({cfg_cpol, cfg_cpha, cfg_lsb_first} == 3'b111, "R3 pol/pha/lsb",
        {cfg_cpol, cfg_cpha, cfg_lsb_first}, 3'b111);
    wr_reg(0, 8'h50); wr_reg(2, 8'h10);

    // R4 unarmed write is ignored
    wr_reg(4, 8'h3C); idle(4);
    chk(n_start == 0, "R4 unarmed write launched", n_start, 0);
    rd_reg(3, v); chk(v == 8'h20, "R4 empty still set", v, 8'h20);

    // R5 armed write launches
    wr_reg(4, 8'hC3); idle(3);
    chk(n_start == 1, "R5 start count", n_start, 1);
    chk(last_byte == 8'hC3, "R5 launched byte", last_byte, 8'hC3);

    // R6 / R7 completion and clear sequence
    idle(10);
    rd_reg(4, v); chk(v == 8'h66, "R6 received byte", v, 8'h66);
    rd_reg(3, v); chk(v == 8'hA0, "R7 complete survives unarmed read", v, 8'hA0);
    rd_reg(4, v); chk(v == 8'h66, "R6 data reread", v, 8'h66);
    rd_reg(3, v); chk(v == 8'h20, "R7 complete cleared", v, 8'h20);

    // R8 interrupt sources
    wr_reg(0, 8'hD0); idle(1);
    chk(irq == 0, "R8 rx irq idle", irq, 0);
    rd_reg(3, v); wr_reg(4, 8'h81); idle(12);
    chk(irq == 1, "R8 rx irq on complete", irq, 1);
    rd_reg(3, v); rd_reg(4, v); idle(1);
    chk(irq == 0, "R8 rx irq after clear", irq, 0);
    wr_reg(0, 8'h70); idle(1);
    chk(irq == 1, "R8 tx irq on empty", irq, 1);
    wr_reg(0, 8'h50);

    // R5 back-to-back: second byte waits for done
    s0 = n_start;
    rd_reg(3, v); wr_reg(4, 8'h11);
    rd_reg(3, v); wr_reg(4, 8'h22);
    idle(20);
    chk(n_start == s0 + 2, "R5 two launches", n_start, s0 + 2);
    chk(last_byte == 8'h22, "R5 second byte", last_byte, 8'h22);
    rd_reg(3, v); rd_reg(4, v);
    chk(v == (8'h22 ^ 8'hA5), "R6 second received byte", v, 8'h22 ^ 8'hA5);

    // R9 abort
    eng_auto = 0;
    s0 = n_start;
    rd_reg(3, v); wr_reg(4, 8'h5A); idle(2);
    rd_reg(3, v); wr_reg(4, 8'h6B); idle(2);
    rd_reg(3, v); chk((v & 8'h20) == 0, "R5 byte held behind busy engine", v & 8'h20, 0);
    wr_reg(0, 8'h10); idle(1);
    rd_reg(3, v); chk(v == 8'h20, "R9 empty after disable", v, 8'h20);
    wr_reg(0, 8'h50);
    req_done = 1; idle(3);
    rd_reg(3, v); chk(v == 8'h20, "R9 stale done ignored", v, 8'h20);
    idle(3);
    chk(n_start == s0 + 1, "R9 held byte dropped", n_start, s0 + 1);
    eng_auto = 1;

    // R10 fault flag
    wr_reg(1, 8'h18);
    @(posedge clk); #1 fault_in = 1; @(posedge clk); #1 fault_in = 0;
    rd_reg(3, v); chk(v == 8'h30, "R10 fault set", v, 8'h30);
    wr_reg(0, 8'h50);
    rd_reg(3, v); chk(v == 8'h20, "R10 fault cleared", v, 8'h20);
    wr_reg(1, 8'h08);
    @(posedge clk); #1 fault_in = 1; @(posedge clk); #1 fault_in = 0;
    rd_reg(3, v); chk(v == 8'h20, "R10 fault masked", v, 8'h20);

    idle(2);
    summary();
  end
endmodule